// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Feedback Divider

This block is the counting core in the feedback path of a frequency synthesizer. It runs on the output clock of an external dual-modulus prescaler. It tells that prescaler, cycle by cycle, whether to divide by P or by P+1. A swallow counter holds the number of P+1 cycles. A main counter holds the length of a division period in prescaler cycles. The block emits a one-cycle feedback pulse at the end of every period, so the oscillator frequency is divided in total by P·N + A.

A 19-bit configuration frame is shifted in serially, most significant bit first. A load strobe then copies it into a pending register. The counters and the ratio select pick up the pending values only when the main counter reaches its terminal count. A period that is already running therefore always finishes with the settings it started with. The ratio select output picks the modulus pair: 64/65 or 128/129.

Top module: `sw_div_top`

## Requirements
- R1: For the cycle after synchronous reset is released, `fb_pulse` is 0, `swallow_req` is 1 (default swallow count 2), and `ratio_sel` is 0. The first period is 16 cycles long with 2 swallow cycles.
- R2: With a main count N ≥ 2, `fb_pulse` is high for exactly one cycle in every N prescaler cycles.
- R3: In each period, `swallow_req` is high for exactly the first A cycles and low for the rest. It never rises again before the period ends.
- R4: The number of oscillator cycles per period equals P·N + A. P is 64 when `ratio_sel` is 0 and 128 when it is 1.
- R5: Each `cfg_shift` cycle shifts `cfg_data` into the frame LSB end, so bits arrive MSB first. In the frame, bit 18 is the ratio select, bits 17:7 are N and bits 6:0 are A.
- R6: After a `cfg_load` strobe, the period in progress completes with the old N, A and ratio. The new values apply from the next period on.
- R7: Shifting data without a `cfg_load` strobe leaves the division unchanged.
- R8: With N = 1, `fb_pulse` stays high in every cycle. The oscillator count per cycle is P + A for A in {0, 1}.
- R9: With A = 0, `swallow_req` is never high. With A = N, it is high in every cycle of the period.

Ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaler output clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_data | input | 1 | Serial configuration bit |
| cfg_shift | input | 1 | Shift enable for the configuration frame |
| cfg_load | input | 1 | Copies the frame into the pending settings |
| swallow_req | output | 1 | 1: prescaler divides by P+1, 0: by P |
| ratio_sel | output | 1 | 0: 64/65 pair, 1: 128/129 pair |
| fb_pulse | output | 1 | One-cycle pulse at the end of each period |

## Verification
The bench models the prescaler. For every period it adds up the oscillator cycles and records the period length and the position of the swallow cycles.

- Random legal settings across both ratios tell a correct P·N + A apart from swapped fields or a wrong modulus.
- The edges N = 1, A = 0, A = N and the maximum N = 2047 with A = 127 expose off-by-one errors in the terminal and swallow counts.
- A load placed in the middle of a period separates deferred reload from immediate reload.
- Shifting a frame with no load strobe shows whether the strobe alone gates the update.

// File: rtl/sw_div_pkg.sv
package sw_div_pkg;
  localparam int SWALLOW_W_DEF = 7;
  localparam int MAIN_W_DEF    = 11;

  typedef enum logic {
    RATIO_64_65   = 1'b0,
    RATIO_128_129 = 1'b1
  } ratio_e;
endpackage

// File: rtl/sw_div_cfg.sv
module sw_div_cfg
  import sw_div_pkg::*;
#(
  parameter int A_W   = SWALLOW_W_DEF,
  parameter int N_W   = MAIN_W_DEF,
  parameter logic [N_W-1:0] DEF_N = 16,
  parameter logic [A_W-1:0] DEF_A = 2,
  parameter ratio_e DEF_RATIO = RATIO_64_65
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cfg_data,
  input  logic           cfg_shift,
  input  logic           cfg_load,
  output logic [N_W-1:0] pend_n,
  output logic [A_W-1:0] pend_a,
  output ratio_e         pend_ratio
);
  localparam int FRAME_W = 1 + N_W + A_W;

  logic [FRAME_W-1:0] frame_q;

  // serial frame, MSB first: the newest bit enters at bit 0
  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (cfg_shift) begin
      frame_q <= {frame_q[FRAME_W-2:0], cfg_data};
    end
  end

  // pending settings change only on the load strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_n     <= DEF_N;
      pend_a     <= DEF_A;
      pend_ratio <= DEF_RATIO;
    end else if (cfg_load) begin
      pend_ratio <= ratio_e'(frame_q[FRAME_W-1]);
      pend_n     <= frame_q[A_W +: N_W];
      pend_a     <= frame_q[A_W-1:0];
    end
  end
endmodule

// File: rtl/sw_div_core.sv
module sw_div_core
  import sw_div_pkg::*;
#(
  parameter int A_W   = SWALLOW_W_DEF,
  parameter int N_W   = MAIN_W_DEF,
  parameter logic [N_W-1:0] DEF_N = 16,
  parameter logic [A_W-1:0] DEF_A = 2,
  parameter ratio_e DEF_RATIO = RATIO_64_65
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N_W-1:0] pend_n,
  input  logic [A_W-1:0] pend_a,
  input  ratio_e         pend_ratio,
  output logic [N_W-1:0] main_rem,
  output logic           swallow_req,
  output logic           ratio_sel,
  output logic           fb_pulse
);
  localparam logic [N_W-1:0] MAIN_TERM = N_W'(1);

  logic [A_W-1:0] swal_rem;
  logic [N_W-1:0] main_nx;
  logic [A_W-1:0] swal_nx;
  logic           at_term;

  assign at_term = (main_rem == MAIN_TERM);

  // both counters reload together at the main terminal count
  always_comb begin
    if (at_term) begin
      main_nx = pend_n;
      swal_nx = pend_a;
    end else begin
      main_nx = main_rem - N_W'(1);
      swal_nx = (swal_rem != '0) ? swal_rem - A_W'(1) : '0;
    end
  end

  // outputs are registered from the next counter state
  always_ff @(posedge clk) begin
    if (rst) begin
      main_rem    <= DEF_N;
      swal_rem    <= DEF_A;
      swallow_req <= (DEF_A != '0);
      fb_pulse    <= (DEF_N == MAIN_TERM);
      ratio_sel   <= DEF_RATIO;
    end else begin
      main_rem    <= main_nx;
      swal_rem    <= swal_nx;
      swallow_req <= (swal_nx != '0);
      fb_pulse    <= (main_nx == MAIN_TERM);
      if (at_term) ratio_sel <= pend_ratio;
    end
  end
endmodule

// File: rtl/sw_div_top.sv
module sw_div_top
  import sw_div_pkg::*;
#(
  parameter int A_W   = SWALLOW_W_DEF,
  parameter int N_W   = MAIN_W_DEF,
  parameter logic [N_W-1:0] DEF_N = 16,
  parameter logic [A_W-1:0] DEF_A = 2,
  parameter ratio_e DEF_RATIO = RATIO_64_65
) (
  input  logic clk,
  input  logic rst,
  input  logic cfg_data,
  input  logic cfg_shift,
  input  logic cfg_load,
  output logic swallow_req,
  output logic ratio_sel,
  output logic fb_pulse
);
  logic [N_W-1:0] pend_n;
  logic [A_W-1:0] pend_a;
  ratio_e         pend_ratio;
  logic [N_W-1:0] main_rem;

  sw_div_cfg #(
    .A_W(A_W), .N_W(N_W), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_RATIO(DEF_RATIO)
  ) u_cfg (
    .clk(clk), .rst(rst), .cfg_data(cfg_data), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .pend_n(pend_n), .pend_a(pend_a),
    .pend_ratio(pend_ratio)
  );

  sw_div_core #(
    .A_W(A_W), .N_W(N_W), .DEF_N(DEF_N), .DEF_A(DEF_A), .DEF_RATIO(DEF_RATIO)
  ) u_core (
    .clk(clk), .rst(rst), .pend_n(pend_n), .pend_a(pend_a),
    .pend_ratio(pend_ratio), .main_rem(main_rem),
    .swallow_req(swallow_req), .ratio_sel(ratio_sel), .fb_pulse(fb_pulse)
  );
endmodule

// File: rtl/sw_div_chk.sv
module sw_div_chk #(
  parameter int A_W = 7,
  parameter int N_W = 11
) (
  input logic           clk,
  input logic           rst,
  input logic           cfg_load,
  input logic           swallow_req,
  input logic           ratio_sel,
  input logic           fb_pulse,
  input logic [N_W-1:0] main_rem,
  input logic [N_W-1:0] pend_n,
  input logic [A_W-1:0] pend_a
);
  // R3: a swallow phase can only begin right after a period boundary
  a_r3_swallow_starts_period: assert property (@(posedge clk) disable iff (rst)
    $rose(swallow_req) |-> $past(fb_pulse));

  // R2: between boundaries the main count steps down by one
  a_r2_main_steps_down: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |=> (main_rem == N_W'($past(main_rem) - 1'b1)));

  // R6: the main count reloads from the pending value after the pulse
  a_r6_reload_from_pending: assert property (@(posedge clk) disable iff (rst)
    fb_pulse |=> (main_rem == $past(pend_n)));

  // R6: ratio select changes only at a period boundary
  a_r6_ratio_held: assert property (@(posedge clk) disable iff (rst)
    !fb_pulse |=> $stable(ratio_sel));

  // R7: pending settings hold without a load strobe
  a_r7_pending_held: assert property (@(posedge clk) disable iff (rst)
    !cfg_load |=> ($stable(pend_n) && $stable(pend_a)));
endmodule

bind sw_div_top sw_div_chk #(.A_W(A_W), .N_W(N_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .swallow_req(swallow_req),
  .ratio_sel(ratio_sel), .fb_pulse(fb_pulse), .main_rem(main_rem),
  .pend_n(pend_n), .pend_a(pend_a)
);

// File: tb/sim_sw_div_top.sv
module sim_sw_div_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_data = 1'b0;
  logic cfg_shift = 1'b0;
  logic cfg_load = 1'b0;
  logic swallow_req, ratio_sel, fb_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sw_div_top u0 (
    .clk(clk), .rst(rst), .cfg_data(cfg_data), .cfg_shift(cfg_shift),
    .cfg_load(cfg_load), .swallow_req(swallow_req), .ratio_sel(ratio_sel),
    .fb_pulse(fb_pulse)
  );

  // prescaler model and period recorder
  int cyc, osc, hi_cnt;
  bit fell_seen, order_ok;
  int r_len, r_osc, r_hi;
  bit r_order;
  int per_cnt = 0;

  always @(negedge clk) begin
    if (rst) begin
      cyc = 0; osc = 0; hi_cnt = 0; fell_seen = 0; order_ok = 1;
    end else begin
      cyc = cyc + 1;
      osc = osc + (ratio_sel ? 128 : 64) + (swallow_req ? 1 : 0);
      if (swallow_req) begin
        hi_cnt = hi_cnt + 1;
        if (fell_seen) order_ok = 0;
      end else begin
        fell_seen = 1;
      end
      if (fb_pulse) begin
        r_len = cyc; r_osc = osc; r_hi = hi_cnt; r_order = order_ok;
        cyc = 0; osc = 0; hi_cnt = 0; fell_seen = 0; order_ok = 1;
        per_cnt = per_cnt + 1;
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_period();
    int c0 = per_cnt;
    wait (per_cnt != c0);
  endtask

  task automatic verify_period(input string req, input int wide, input int n, input int a);
    wait_period();
    check(req, "period length", r_len, n);
    check(req, "oscillator cycles", r_osc, (wide ? 128 : 64) * n + a);
    check(req, "swallow cycles", r_hi, a);
    check(req, "swallow first", int'(r_order), 1);
  endtask

  task automatic shift_frame(input int wide, input int n, input int a);
    logic [18:0] fr = {wide[0], n[10:0], a[6:0]};
    for (int i = 18; i >= 0; i--) begin
      cfg_shift = 1'b1; cfg_data = fr[i];
      @(negedge clk);
    end
    cfg_shift = 1'b0; cfg_data = 1'b0;
  endtask

  task automatic load_cfg(input int wide, input int n, input int a);
    shift_frame(wide, n, a);
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1", "fb_pulse after reset", int'(fb_pulse), 0);
    check("R1", "swallow_req after reset", int'(swallow_req), 1);
    check("R1", "ratio_sel after reset", int'(ratio_sel), 0);
    verify_period("R1", 0, 16, 2);
  endtask

  task automatic t_setting(input string req, input int wide, input int n, input int a);
    load_cfg(wide, n, a);
    wait_period();
    verify_period(req, wide, n, a);
    verify_period(req, wide, n, a);
  endtask

  task automatic t_random();
    for (int k = 0; k < 6; k++) begin
      int n = $urandom_range(200, 2);
      int a = $urandom_range((n < 127) ? n : 127, 0);
      int w = $urandom_range(1, 0);
      t_setting("R4", w, n, a);
    end
  endtask

  // R6: load during a running period, old values must finish it
  task automatic t_mid_load();
    load_cfg(0, 60, 10);
    wait_period();
    wait_period();
    load_cfg(1, 30, 3);
    verify_period("R6", 0, 60, 10);
    verify_period("R6", 1, 30, 3);
  endtask

  // R7: shifting a frame without the load strobe changes nothing
  task automatic t_no_load();
    load_cfg(0, 25, 7);
    wait_period();
    shift_frame(1, 90, 40);
    #1;
    verify_period("R7", 0, 25, 7);
    verify_period("R7", 0, 25, 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_setting("R5", 1, 37, 5);
    t_setting("R2", 0, 50, 20);
    t_random();
    t_mid_load();
    t_no_load();
    t_setting("R8", 0, 1, 0);
    t_setting("R8", 0, 1, 1);
    t_setting("R9", 1, 100, 0);
    t_setting("R9", 1, 100, 100);
    t_setting("R4", 1, 2047, 127);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule